// File: doc/BRIEF.md
# Master/Slave Line and Frame Timing Generator

This block produces the row timing for a passive-matrix display driver. It generates a one-cycle line pulse, a frame marker, a polarity signal that alternates once per frame, and a shift clock. It also keeps the row counter that supplies the read address of the display memory. The counter runs on the line pulse alone, so it never waits on host accesses to that memory. The design is clocked by one system clock. Two tick enables stand for the two timing sources, an external clock and an on-chip oscillator, and a select input decides which one paces the line timer.

The mode pin sets the role of the chip. In master mode the block generates all timing itself and raises a registered output enable for the line, frame and polarity pins. In slave mode it stops its own pulse generation and holds those outputs and the shift clock low. It then follows the line and frame inputs from the master chip, and the row counter keeps stepping on the external line pulse.

A four-state controller sequences the modes. ST_IDLE is entered on reset. It goes to ST_MASTER when the mode pin is high and to ST_SLAVE when it is low. ST_MASTER goes to ST_SWITCH when the mode pin falls. ST_SLAVE goes to ST_SWITCH when the mode pin rises. ST_SWITCH clears all timing state for one cycle and then goes to ST_MASTER or ST_SLAVE according to the mode pin.

Top module: `lcdt_timing_gen`

## Requirements
- R1: While rst_n is low and in the first cycle after it, lp_out, flm_out, m_out, sclk_out and timing_oe are 0 and row_addr is 0.
- R2: In master mode only the tick picked by src_sel advances the timing (1 selects osc_tick, 0 selects ext_tick). The other tick has no effect on any output.
- R3: In master mode lp_out is high for exactly one cycle, in the cycle after every LINE_TICKS-th selected tick.
- R4: flm_out is high only together with lp_out, and only for the line pulse that ends row NUM_LINES-1 (129 by default).
- R5: In the cycle after each master line pulse, row_addr is one higher. After the line pulse that carries flm_out it is 0, so rows run 0 to NUM_LINES-1.
- R6: In master mode m_out inverts in the cycle after each pulse where lp_out and flm_out are both high. It starts at 0 whenever master operation begins.
- R7: In master mode sclk_out inverts in the cycle after each selected tick. Outside master mode it stays 0.
- R8: When timing_oe is low, lp_out, flm_out, m_out and sclk_out are 0, and drive_pol equals m_in (otherwise drive_pol equals m_out). In slave mode each cycle with lp_in high moves row_addr one step in the next cycle. The step goes to 0 if flm_in is high or the row is NUM_LINES-1.
- R9: timing_oe changes only after reset or a mode change. It falls at the first clock edge that samples mode_master low in master mode. It rises at the first edge after reset with mode_master high, or one cycle after ST_SWITCH when mode_master is high. Each mode change clears the row counter, the tick count and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_master | input | 1 | 1 = master, 0 = slave |
| src_sel | input | 1 | Timing source select: 1 = oscillator tick, 0 = external tick |
| ext_tick | input | 1 | Tick enable from the external clock |
| osc_tick | input | 1 | Tick enable from the internal oscillator |
| lp_in | input | 1 | Line pulse from the master chip (slave mode) |
| flm_in | input | 1 | Frame marker from the master chip (slave mode) |
| m_in | input | 1 | Polarity from the master chip (slave mode) |
| lp_out | output | 1 | Generated line pulse |
| flm_out | output | 1 | Generated frame marker |
| m_out | output | 1 | Generated frame polarity |
| sclk_out | output | 1 | Shift clock, held low outside master mode |
| timing_oe | output | 1 | Registered output enable for the line, frame and polarity pins |
| drive_pol | output | 1 | Polarity used by the drive stage |
| row_addr | output | $clog2(NUM_LINES) | Display memory row read address |

## Verification
An error in the tick counter shows up as a line pulse one or more cycles early or late, and the row address then steps at the wrong time in the very next cycle. A wrong row count is visible in two ways. The row address differs from the model at once, and the frame marker comes with the wrong row, which then flips the polarity in the wrong frame. A controller stuck in the wrong state shows at the ports within one or two cycles of a mode change, as a wrong output enable, a row address that is not cleared, or slave outputs that are not held low. The bench compares every port against a behavioural model on every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MASTER = 2'd1,
        ST_SLAVE  = 2'd2,
        ST_SWITCH = 2'd3
    } lcdt_state_e;

endpackage

// File: rtl/lcdt_mode_fsm.sv
module lcdt_mode_fsm
    import lcdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_master,
    output logic run_master,
    output logic run_slave,
    output logic timing_oe
);

    lcdt_state_e state_q;
    lcdt_state_e state_n;

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   state_n = mode_master ? ST_MASTER : ST_SLAVE;
            ST_MASTER: if (!mode_master) state_n = ST_SWITCH;
            ST_SLAVE:  if (mode_master)  state_n = ST_SWITCH;
            ST_SWITCH: state_n = mode_master ? ST_MASTER : ST_SLAVE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // run strobes steer the datapath for the coming cycle
    always_comb begin
        run_master = (state_n == ST_MASTER);
        run_slave  = (state_n == ST_SLAVE);
    end

    // registered pin direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timing_oe <= 1'b0;
        end else begin
            timing_oe <= (state_n == ST_MASTER);
        end
    end

endmodule

// File: rtl/lcdt_line_timer.sv
module lcdt_line_timer #(
    parameter int LINE_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic last_row,
    output logic lp,
    output logic flm,
    output logic sclk,
    output logic m_pol
);

    localparam int CNT_W = (LINE_TICKS > 1) ? $clog2(LINE_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LINE_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             end_line;

    always_comb begin
        end_line = tick && (cnt_q == CNT_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lp    <= 1'b0;
            flm   <= 1'b0;
            sclk  <= 1'b0;
            m_pol <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            lp    <= 1'b0;
            flm   <= 1'b0;
            sclk  <= 1'b0;
            m_pol <= 1'b0;
        end else begin
            if (tick) begin
                cnt_q <= end_line ? '0 : cnt_q + CNT_W'(1);
                sclk  <= ~sclk;
            end
            lp  <= end_line;
            flm <= end_line && last_row;
            if (lp && flm) begin
                m_pol <= ~m_pol;
            end
        end
    end

endmodule

// File: rtl/lcdt_row_counter.sv
module lcdt_row_counter #(
    parameter int NUM_LINES = 130,
    localparam int ROW_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             adv,
    input  logic             frame_sync,
    output logic [ROW_W-1:0] row,
    output logic             last_row
);

    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_LINES - 1);

    always_comb begin
        last_row = (row == ROW_LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
        end else if (clear) begin
            row <= '0;
        end else if (adv) begin
            row <= (frame_sync || last_row) ? '0 : row + ROW_W'(1);
        end
    end

endmodule

// File: rtl/lcdt_timing_gen.sv
module lcdt_timing_gen #(
    parameter int NUM_LINES  = 130,
    parameter int LINE_TICKS = 8,
    localparam int ROW_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_master,
    input  logic             src_sel,
    input  logic             ext_tick,
    input  logic             osc_tick,
    input  logic             lp_in,
    input  logic             flm_in,
    input  logic             m_in,
    output logic             lp_out,
    output logic             flm_out,
    output logic             m_out,
    output logic             sclk_out,
    output logic             timing_oe,
    output logic             drive_pol,
    output logic [ROW_W-1:0] row_addr
);

    logic run_master;
    logic run_slave;
    logic tick;
    logic last_row;
    logic row_adv;
    logic row_sync;
    logic row_clear;

    lcdt_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_master (mode_master),
        .run_master  (run_master),
        .run_slave   (run_slave),
        .timing_oe   (timing_oe)
    );

    always_comb begin
        tick      = src_sel ? osc_tick : ext_tick;
        row_clear = !(run_master || run_slave);
        row_adv   = run_master ? lp_out  : (run_slave && lp_in);
        row_sync  = run_master ? flm_out : flm_in;
        drive_pol = timing_oe ? m_out : m_in;
    end

    lcdt_line_timer #(
        .LINE_TICKS (LINE_TICKS)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_master),
        .tick     (tick),
        .last_row (last_row),
        .lp       (lp_out),
        .flm      (flm_out),
        .sclk     (sclk_out),
        .m_pol    (m_out)
    );

    lcdt_row_counter #(
        .NUM_LINES (NUM_LINES)
    ) u_row (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (row_clear),
        .adv        (row_adv),
        .frame_sync (row_sync),
        .row        (row_addr),
        .last_row   (last_row)
    );

endmodule

// File: rtl/lcdt_timing_chk.sv
module lcdt_timing_chk #(
    parameter int NUM_LINES = 130,
    localparam int ROW_W = $clog2(NUM_LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_master,
    input logic             lp_out,
    input logic             flm_out,
    input logic             m_out,
    input logic             sclk_out,
    input logic             timing_oe,
    input logic [ROW_W-1:0] row_addr
);

    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_LINES - 1);

    AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !timing_oe |-> (!lp_out && !flm_out && !m_out && !sclk_out)); // R8

    AST_LP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lp_out |=> !lp_out); // R3

    AST_FLM_INSIDE_LP: assert property (@(posedge clk) disable iff (!rst_n)
        flm_out |-> lp_out); // R4

    AST_FLM_ON_LAST_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (flm_out && timing_oe) |-> (row_addr == ROW_LAST)); // R4

    AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        row_addr <= ROW_LAST); // R5

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_oe && mode_master && lp_out && !flm_out)
        |=> (row_addr == $past(row_addr) + ROW_W'(1))); // R5

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_oe && lp_out && flm_out) |=> (row_addr == '0)); // R5

    AST_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_oe && mode_master && lp_out && flm_out) |=> (m_out != $past(m_out))); // R6

    AST_OE_RISE_ON_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timing_oe) |-> $past(mode_master)); // R9

    AST_OE_FALL_ON_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timing_oe) |-> !$past(mode_master)); // R9

endmodule

bind lcdt_timing_gen lcdt_timing_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_master (mode_master),
    .lp_out      (lp_out),
    .flm_out     (flm_out),
    .m_out       (m_out),
    .sclk_out    (sclk_out),
    .timing_oe   (timing_oe),
    .row_addr    (row_addr)
);

// File: tb/tb_lcdt_timing_gen.sv
module tb_lcdt_timing_gen;

    localparam int NL = 130;
    localparam int LT = 4;
    localparam int RW = $clog2(NL);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_master = 1'b0;
    logic src_sel = 1'b0;
    logic ext_tick = 1'b0;
    logic osc_tick = 1'b0;
    logic lp_in = 1'b0;
    logic flm_in = 1'b0;
    logic m_in = 1'b0;
    logic lp_out, flm_out, m_out, sclk_out, timing_oe, drive_pol;
    logic [RW-1:0] row_addr;

    int n_vec = 0;
    int n_bad = 0;
    bit in_reset = 1'b1;

    // reference model state
    int act = 0; // 0 none, 1 master, 2 slave
    int tcnt = 0;
    int e_row = 0;
    bit e_lp = 0, e_flm = 0, e_m = 0, e_clk = 0, e_oe = 0;

    always #5 clk = ~clk;

    lcdt_timing_gen #(.NUM_LINES(NL), .LINE_TICKS(LT)) dut (
        .clk (clk), .rst_n (rst_n), .mode_master (mode_master),
        .src_sel (src_sel), .ext_tick (ext_tick), .osc_tick (osc_tick),
        .lp_in (lp_in), .flm_in (flm_in), .m_in (m_in),
        .lp_out (lp_out), .flm_out (flm_out), .m_out (m_out),
        .sclk_out (sclk_out), .timing_oe (timing_oe),
        .drive_pol (drive_pol), .row_addr (row_addr)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act = 0; tcnt = 0; e_row = 0;
            e_lp = 0; e_flm = 0; e_m = 0; e_clk = 0; e_oe = 0;
        end else begin
            if (act == 0)                     act = mode_master ? 1 : 2;
            else if (act == 1 && !mode_master) act = 0;
            else if (act == 2 && mode_master)  act = 0;
            if (act == 1) begin
                bit t, nlp, nflm;
                t    = src_sel ? osc_tick : ext_tick;
                nlp  = t && (tcnt == LT - 1);
                nflm = nlp && (e_row == NL - 1);
                if (e_lp) e_row = e_flm ? 0 : e_row + 1;
                if (e_lp && e_flm) e_m = !e_m;
                if (t) begin
                    e_clk = !e_clk;
                    tcnt = (tcnt + 1) % LT;
                end
                e_lp = nlp; e_flm = nflm; e_oe = 1;
            end else begin
                e_lp = 0; e_flm = 0; e_m = 0; e_clk = 0; tcnt = 0; e_oe = 0;
                if (act == 2) begin
                    if (lp_in) e_row = (flm_in || e_row == NL - 1) ? 0 : e_row + 1;
                end else begin
                    e_row = 0;
                end
            end
        end
    end

    task automatic cmp(input string tag, input int act_v, input int exp_v);
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act_v, exp_v);
        end
    endtask

    task automatic check_all();
        bit ep;
        n_vec++;
        ep = e_oe ? e_m : m_in;
        if (in_reset) begin
            cmp("R1 reset lp_out", lp_out, 0);
            cmp("R1 reset flm_out", flm_out, 0);
            cmp("R1 reset m_out", m_out, 0);
            cmp("R1 reset sclk_out", sclk_out, 0);
            cmp("R1 reset timing_oe", timing_oe, 0);
            cmp("R1 reset row_addr", int'(row_addr), 0);
        end else begin
            cmp("R2 R3 lp_out", lp_out, e_lp);
            cmp("R4 flm_out", flm_out, e_flm);
            cmp("R6 m_out", m_out, e_m);
            cmp("R7 sclk_out", sclk_out, e_clk);
            cmp("R9 timing_oe", timing_oe, e_oe);
            cmp("R8 drive_pol", drive_pol, ep);
            cmp(e_oe ? "R5 row_addr" : "R8 row_addr", int'(row_addr), e_row);
        end
    endtask

    // one cycle per iteration: check outputs, then apply new inputs
    task automatic drive(input bit md, input bit sel, input int ext_p, input int osc_p,
                         input int lp_p, input int flm_p, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_all();
            mode_master = md;
            src_sel     = sel;
            ext_tick    = ($urandom % 100) < ext_p;
            osc_tick    = ($urandom % 100) < osc_p;
            lp_in       = ($urandom % 100) < lp_p;
            flm_in      = ($urandom % 100) < flm_p;
            m_in        = $urandom % 2;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: outputs idle during reset
        mode_master = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check_all();
        end
        rst_n = 1'b1;
        in_reset = 1'b0;
        // R2 R3 R4 R5 R6 R7: master, external source, tick every cycle, oscillator noise ignored
        drive(1, 0, 100, 30, 50, 50, 1200);
        // R2: master, oscillator source, external noise ignored
        drive(1, 1, 50, 60, 50, 50, 3000);
        // R8 R9: slave, row wraps past the last line without frame marker
        drive(0, 1, 70, 70, 50, 0, 400);
        // R8: slave with external frame markers
        drive(0, 0, 70, 70, 40, 5, 400);
        // R9: back to master, short slave burst, then master again
        drive(1, 1, 90, 90, 30, 30, 300);
        drive(0, 1, 90, 90, 60, 0, 3);
        drive(1, 0, 80, 20, 30, 30, 200);
        drive(1, 0, 80, 20, 30, 30, 1);
        finish_run();
    end

endmodule